// File: doc/BRIEF.md
# One-shot converter strobe sequencer

This block generates the clock for a sampling converter that is run in one-shot fashion to catch transient signals. When no conversion is in progress, the converter clock rests at a standby level that depends on the selected mode. A start request then produces a fixed pattern of one or two pulses, timed in system-clock cycles. After the edge that moves the result into the converter's output register, the block waits for a programmed output-delay count and then raises a one-cycle done pulse.

Three patterns are available. The first rests high and uses a single low pulse. The second rests low and uses two high pulses. The third rests high and uses two low pulses. In the first pattern the converter holds its sample on a capacitor between conversions. For that case the block raises a stale warning once the high rest has lasted long enough for the held charge to droop. The warning clears when the next conversion is accepted. Pulse width, gap width, output delay and the droop limit are all parameters.

Top module: `strobe_sequencer`

## Requirements
- R1: The mode input is encoded as 0 = single low pulse, 1 = two high pulses, 2 = two low pulses, and 3 behaves exactly like 0. While idle, `cnv_clk` rests high for modes 0, 2 and 3 and low for mode 1. A mode change made while idle shows on `cnv_clk` in the cycle after the change.
- R2: In mode 0, let cycle 1 be the first cycle after the clock edge that accepts a start. `cnv_clk` is low in cycles 1 to PULSE_CYC and high from then on. The transfer edge is the return to high, in cycle PULSE_CYC+1.
- R3: In mode 1, `cnv_clk` is high in cycles 1 to PULSE_CYC and in cycles PULSE_CYC+GAP_CYC+1 to 2·PULSE_CYC+GAP_CYC, and low otherwise. The transfer edge is the rise of the second pulse, in cycle PULSE_CYC+GAP_CYC+1.
- R4: In mode 2, `cnv_clk` is low in cycles 1 to PULSE_CYC and in cycles PULSE_CYC+GAP_CYC+1 to 2·PULSE_CYC+GAP_CYC, and high otherwise. The transfer edge is the end of the second pulse, in cycle 2·PULSE_CYC+GAP_CYC+1.
- R5: `done` is high for exactly one cycle, OUT_DLY_CYC cycles after the transfer-edge cycle. It is low in every other cycle.
- R6: A start is accepted only while idle. A start raised while busy has no effect. The mode is captured when the start is accepted, and a later change of `mode_sel` does not alter the running pattern.
- R7: `busy` is high from cycle 1 until the block is idle again. In modes 0 and 2 it returns low in the cycle in which `done` is high. In mode 1 it returns low in the later of the done cycle and the cycle after the second pulse ends.
- R8: `stale` goes high in the cycle in which STALE_CYC consecutive idle cycles with mode 0 or 3 have elapsed, counted from the first such idle cycle. It is low in the cycle after a start is accepted, and it never rises while mode 1 or 2 is selected.
- R9: During and right after reset, `busy`, `done` and `stale` are low and `cnv_clk` rests at the level of the selected mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_sel | input | 2 | Pulse pattern select (see R1) |
| start | input | 1 | Conversion request, sampled while idle |
| cnv_clk | output | 1 | Registered clock to the converter |
| busy | output | 1 | Conversion sequence in progress |
| done | output | 1 | One-cycle pulse: converter data valid |
| stale | output | 1 | Held sample may have drooped (mode 0/3) |

## Verification
A wrong sequencer state shows on `cnv_clk` at once: a pulse that is too long or too short, or a missing second pulse, is off by a level in a specific cycle of the trace. Errors in the delay counter or the captured mode show up only a few cycles later, as a `done` in the wrong cycle or a `busy` that drops at the wrong time. A droop counter that is off is the slowest fault to appear: it shows only as a `stale` rise shifted away from cycle STALE_CYC of the idle run, or as a warning that survives a newly accepted start.

// File: rtl/strobe_pkg.sv
package strobe_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PULSE1 = 3'd1,
    ST_GAP    = 3'd2,
    ST_PULSE2 = 3'd3,
    ST_WAIT   = 3'd4
  } seq_state_t;

  localparam logic [1:0] MD_HI_ONE = 2'd0;
  localparam logic [1:0] MD_LO_TWO = 2'd1;
  localparam logic [1:0] MD_HI_TWO = 2'd2;

  // standby level of the converter clock for a mode
  function automatic logic rest_level(input logic [1:0] m);
    return m != MD_LO_TWO;
  endfunction

  function automatic logic two_pulse(input logic [1:0] m);
    return (m == MD_LO_TWO) || (m == MD_HI_TWO);
  endfunction

  // modes whose standby holds a sample that can droop
  function automatic logic holds_charge(input logic [1:0] m);
    return !two_pulse(m);
  endfunction

endpackage

// File: rtl/span_timer.sv
module span_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         last
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign last = (cnt == W'(1));

  a_r2_timer_nonzero_load: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt != '0));
endmodule

// File: rtl/done_delay.sv
module done_delay #(
  parameter int DLY = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic trig,
  output logic active,
  output logic near_end,
  output logic done
);
  localparam int W = $clog2(DLY + 1);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= (cnt == W'(1)) && !trig;
      if (trig)             cnt <= W'(DLY);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
  end

  assign active   = (cnt != '0);
  assign near_end = (cnt == W'(1));

  a_r5_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
endmodule

// File: rtl/droop_watch.sv
module droop_watch #(
  parameter int LIMIT = 500
) (
  input  logic clk,
  input  logic rst,
  input  logic count_en,
  output logic stale
);
  localparam int W = $clog2(LIMIT + 1);
  logic [W-1:0] cnt, cnt_n;

  always_comb begin
    if (!count_en)               cnt_n = '0;
    else if (cnt == W'(LIMIT))   cnt_n = cnt;
    else                         cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      stale <= 1'b0;
    end else begin
      cnt   <= cnt_n;
      stale <= (cnt_n == W'(LIMIT));
    end
  end

  a_r8_stale_needs_count: assert property (@(posedge clk) disable iff (rst)
    $rose(stale) |-> $past(count_en));
endmodule

// File: rtl/strobe_sequencer.sv
module strobe_sequencer
  import strobe_pkg::*;
#(
  parameter int PULSE_CYC   = 2,
  parameter int GAP_CYC     = 1,
  parameter int OUT_DLY_CYC = 1,
  parameter int STALE_CYC   = 500
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       start,
  output logic       cnv_clk,
  output logic       busy,
  output logic       done,
  output logic       stale
);
  localparam int SPAN_MAX = (PULSE_CYC > GAP_CYC) ? PULSE_CYC : GAP_CYC;
  localparam int TW       = $clog2(SPAN_MAX + 1);

  seq_state_t   state, nxt;
  logic [1:0]   mode_q, mode_eff;
  logic         accept, t_load, t_last, xfer, d_active, d_near, clk_n;
  logic [TW-1:0] t_val;

  assign accept   = (state == ST_IDLE) && start;
  assign mode_eff = (state == ST_IDLE) ? mode_sel : mode_q;

  span_timer #(.W(TW)) timer_i (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .last(t_last));

  done_delay #(.DLY(OUT_DLY_CYC)) delay_i (
    .clk(clk), .rst(rst), .trig(xfer),
    .active(d_active), .near_end(d_near), .done(done));

  droop_watch #(.LIMIT(STALE_CYC)) droop_i (
    .clk(clk), .rst(rst),
    .count_en((state == ST_IDLE) && holds_charge(mode_sel) && !start),
    .stale(stale));

  always_comb begin
    nxt    = state;
    t_load = 1'b0;
    t_val  = TW'(PULSE_CYC);
    xfer   = 1'b0;
    unique case (state)
      ST_IDLE: if (start) begin
        nxt    = ST_PULSE1;
        t_load = 1'b1;
      end
      ST_PULSE1: if (t_last) begin
        if (two_pulse(mode_q)) begin
          nxt    = ST_GAP;
          t_load = 1'b1;
          t_val  = TW'(GAP_CYC);
        end else begin
          nxt  = ST_WAIT;
          xfer = 1'b1;
        end
      end
      ST_GAP: if (t_last) begin
        nxt    = ST_PULSE2;
        t_load = 1'b1;
        xfer   = (mode_q == MD_LO_TWO);  // transfer on leading edge
      end
      ST_PULSE2: if (t_last) begin
        if (mode_q == MD_HI_TWO) begin
          nxt  = ST_WAIT;
          xfer = 1'b1;
        end else begin
          nxt = (d_active && !d_near) ? ST_WAIT : ST_IDLE;
        end
      end
      ST_WAIT: if (d_near) nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    if (nxt == ST_IDLE)
      clk_n = rest_level(mode_sel);
    else if (nxt == ST_PULSE1 || nxt == ST_PULSE2)
      clk_n = !rest_level(mode_eff);
    else
      clk_n = rest_level(mode_eff);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      mode_q  <= MD_HI_ONE;
      cnv_clk <= rest_level(mode_sel);
    end else begin
      state   <= nxt;
      cnv_clk <= clk_n;
      if (accept) mode_q <= mode_sel;
    end
  end

  assign busy = (state != ST_IDLE);

  a_r6_mode_held: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(mode_q));
  a_r8_stale_only_idle: assert property (@(posedge clk) disable iff (rst)
    stale |-> !busy);
  a_r1_rest_level: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && $past(state == ST_IDLE)) |->
      (cnv_clk == rest_level($past(mode_sel))));
  a_r6_start_leaves_idle: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_IDLE) && start) |=> busy);
endmodule

// File: tb/strobe_sequencer_tb_top.sv
module strobe_sequencer_tb_top;
  localparam int P = 3, G = 2, D = 2, ST = 40;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [1:0] mode_sel = 2'd0;
  logic cnv_clk, busy, done, stale;
  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  strobe_sequencer #(.PULSE_CYC(P), .GAP_CYC(G), .OUT_DLY_CYC(D), .STALE_CYC(ST)) dut_i (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .start(start),
    .cnv_clk(cnv_clk), .busy(busy), .done(done), .stale(stale));

  task automatic chk(input bit ok, input string req, input int act, input int exp, input int k);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cycle %0d: actual %0d expected %0d", req, k, act, exp);
    end
  endtask

  function automatic bit rest_of(input int m);
    return m != 1;
  endfunction

  // run one conversion, checking every cycle from k=1 to len
  task automatic conv(input int mode, input bit disturb, input int len);
    int t_x, idle_k, done_k;
    bit st, lvl;
    @(negedge clk); mode_sel = 2'(mode);
    @(negedge clk);
    chk(cnv_clk == rest_of(mode), "R1 idle level", cnv_clk, rest_of(mode), 0);
    start = 1'b1;
    @(negedge clk); start = 1'b0;
    st = rest_of(mode);
    if (mode == 1)      t_x = P + G + 1;
    else if (mode == 2) t_x = 2*P + G + 1;
    else                t_x = P + 1;
    done_k = t_x + D;
    idle_k = done_k;
    if (mode == 1 && t_x + P > idle_k) idle_k = t_x + P;
    for (int k = 1; k <= len; k++) begin
      lvl = st;
      if (k >= 1 && k <= P) lvl = !st;
      if ((mode == 1 || mode == 2) && k >= P+G+1 && k <= 2*P+G) lvl = !st;
      case (mode)
        0, 3: chk(cnv_clk == lvl, "R2 mode0 level", cnv_clk, lvl, k);
        1:    chk(cnv_clk == lvl, "R3 mode1 level", cnv_clk, lvl, k);
        default: chk(cnv_clk == lvl, "R4 mode2 level", cnv_clk, lvl, k);
      endcase
      chk(done == (k == done_k), "R5 done timing", done, k == done_k, k);
      chk(busy == (k < idle_k), "R7 busy", busy, k < idle_k, k);
      chk(stale == ((mode == 0 || mode == 3) && k >= idle_k + ST),
          "R8 stale", stale, (mode == 0 || mode == 3) && k >= idle_k + ST, k);
      if (disturb) begin  // R6: start and mode change while busy
        if (k == 2) begin start = 1'b1; mode_sel = 2'((mode + 1) % 3); end
        if (k == 3) begin start = 1'b0; mode_sel = 2'(mode); end
        if (k == idle_k - 1) start = 1'b1;
        if (k == idle_k) start = 1'b0;
      end
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cnv_clk == 1'b1, "R9 reset clk", cnv_clk, 1, 0);
    chk(!busy && !done && !stale, "R9 reset flags", {busy, done, stale}, 0, 0);
    mode_sel = 2'd1;
    @(negedge clk);
    chk(cnv_clk == 1'b0, "R9 reset follows mode", cnv_clk, 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !done && !stale, "R9 after reset", {busy, done, stale}, 0, 0);
    conv(0, 1'b0, 50);
    conv(1, 1'b0, 60);
    conv(2, 1'b0, 20);
    conv(3, 1'b0, 50);
    conv(0, 1'b1, 50);
    conv(1, 1'b1, 20);
    conv(2, 1'b1, 60);
    conv(3, 1'b1, 20);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule